// File: doc/BRIEF.md
# Prioritized External Interrupt Controller

This block gathers up to 32 interrupt lines from outside the chip and turns them into one interrupt request for a CPU. Each line passes through a two-flop synchronizer. It then feeds a detector whose kind is fixed at build time: level or edge, active high/rising or active low/falling. A line that fires while its enable bit is set latches a pending flag. The lowest-numbered pending line is reported as the source to service. The single request line to the CPU stays up until software acknowledges it.

Software sees four word registers, selected by address bits 3:2:

| Word | Register | Access |
|------|----------|--------|
| 0 | enable | read/write |
| 1 | pending | read; a written 0 clears a flag |
| 2 | source index | reads the index in bits 4:0; a write of any value acknowledges |
| 3 | unused | reads as zero, writes ignored |

A handler normally reads the source index, clears that pending flag and then writes the source register. After that write the block looks at the pending flags again and raises a new request if any flag is still set.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Only the lowest NUM_CH input lines are used. Input bits at or above NUM_CH never set a flag, and enable and pending bits at or above NUM_CH always read 0.
- R2: A level channel (type bit 0) sets its pending flag on every cycle in which its synchronized input is at the active level and the channel is enabled. Polarity bit 1 means the active level is high; polarity bit 0 means it is low. A level applied before a rising clock edge shows as pending after the third edge.
- R3: An edge channel (type bit 1) sets its flag once per transition of the synchronized input. Polarity bit 1 selects 0-to-1 transitions and polarity bit 0 selects 1-to-0 transitions. A steady input does not set the flag again after it has been cleared.
- R4: A flag can be set only while the channel's enable bit is set. A flag that is already set stays set when its enable bit is cleared.
- R5: A write to the pending register (word 1) clears each flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. If a trigger and a clear hit the same bit in the same cycle, the flag stays set.
- R6: The source register (word 2) reads, in bits 4:0, the lowest index whose pending flag is set. Bits 31:5 read 0. It reads 0 when no flag is set.
- R7: When no request is outstanding and at least one flag is set, `cpu_irq_o` rises on the next clock edge.
- R8: Once raised, `cpu_irq_o` stays high until a write of any value to word 2, even if all flags are cleared. It is low in the cycle after that write. If a flag is still set, it rises again one cycle later.
- R9: Word 0 reads back the enable register. Word 3 reads 0, and writes to word 3 change nothing.
- R10: After reset, all registers read 0 and `cpu_irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 32 | External interrupt lines, channel n on bit n |
| bus_we_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 2 | Word select (address bits 3:2) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected word, combinational |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |

## Verification
A wrong pending flag becomes visible at the ports within one cycle, as soon as the pending or source word is read. The request line also shows it: a stray or missing flag changes `cpu_irq_o` one cycle after the flag changes. A broken request latch shows either as a request that drops without an acknowledge, or as a request that fails to come back in the cycle after an acknowledge while flags are still set. Errors in the synchronizer or detector shift the arrival of a flag away from the third edge after the input changes, or make an edge channel fire again while its input is steady. The bench compares every cycle against a cycle-accurate model, so such a shift is caught at the first cycle where it differs.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned MAX_CH = 32;
  localparam int unsigned ID_W   = 5;

  typedef enum logic [1:0] {
    WORD_ENABLE  = 2'd0,
    WORD_PENDING = 2'd1,
    WORD_SOURCE  = 2'd2,
    WORD_UNUSED  = 2'd3
  } word_sel_e;
endpackage

// File: rtl/irq_chan_front.sv
module irq_chan_front #(
  parameter bit EDGE_MODE = 1'b0,
  parameter bit ACT_HIGH  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic enable_i,
  output logic fire_o
);
  logic meta_q, sync_q, prev_q;
  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  generate
    if (EDGE_MODE) begin : g_edge
      if (ACT_HIGH) begin : g_rise
        assign hit = sync_q & ~prev_q;
      end else begin : g_fall
        assign hit = ~sync_q & prev_q;
      end
    end else begin : g_level
      if (ACT_HIGH) begin : g_high
        assign hit = sync_q;
      end else begin : g_low
        assign hit = ~sync_q;
      end
    end
  endgenerate

  assign fire_o = hit & enable_i;

  generate
    if (EDGE_MODE) begin : g_chk_edge
      // R3: an edge detector never fires on two cycles in a row
      assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
    end
  endgenerate
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ch_mask_i,
  input  logic [31:0] fire_i,
  input  logic [31:0] enable_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] pend_o
);
  logic [31:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (wr_i) pend_d = pend_q & wdata_i;
    pend_d = (pend_d | fire_i) & ch_mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~ch_mask_i) == 32'd0);
  assert_gate_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~$past(pend_q) & ~$past(enable_i)) == 32'd0);
  assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  assert_trigger_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & $past(fire_i)) == ($past(fire_i) & ch_mask_i)));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic [31:0]     pend_i,
  output logic [ID_W-1:0] id_o,
  output logic            any_o
);
  always_comb begin
    id_o  = '0;
    any_o = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        id_o  = ID_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_CH         = 32,
  parameter logic [31:0] TRIG_EDGE_MASK = 32'h0000_0000,
  parameter logic [31:0] TRIG_HIGH_MASK = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] irq_lines_i,
  input  logic        bus_we_i,
  input  logic [3:2]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        cpu_irq_o
);
  localparam logic [31:0] CH_MASK = (NUM_CH >= MAX_CH) ? 32'hFFFF_FFFF
                                                       : ((32'd1 << NUM_CH) - 32'd1);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  word_sel_e sel;
  logic      wr_enable, wr_pending, wr_ack;

  assign sel        = word_sel_e'(bus_addr_i);
  assign wr_enable  = bus_we_i && (sel == WORD_ENABLE);
  assign wr_pending = bus_we_i && (sel == WORD_PENDING);
  assign wr_ack     = bus_we_i && (sel == WORD_SOURCE);

  logic [31:0] enable_q, enable_d;

  always_comb begin
    enable_d = enable_q;
    if (wr_enable) enable_d = bus_wdata_i & CH_MASK;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) enable_q <= '0;
    else            enable_q <= enable_d;
  end

  logic [31:0] fire;

  for (genvar ch = 0; ch < MAX_CH; ch++) begin : g_ch
    if (ch < NUM_CH) begin : g_used
      irq_chan_front #(
        .EDGE_MODE (TRIG_EDGE_MASK[ch]),
        .ACT_HIGH  (TRIG_HIGH_MASK[ch])
      ) u_front (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .line_i   (irq_lines_i[ch]),
        .enable_i (enable_q[ch]),
        .fire_o   (fire[ch])
      );
    end else begin : g_unused
      assign fire[ch] = 1'b0;
    end
  end

  logic [31:0] pend;

  irq_pending_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ch_mask_i (CH_MASK),
    .fire_i    (fire),
    .enable_i  (enable_q),
    .wr_i      (wr_pending),
    .wdata_i   (bus_wdata_i),
    .pend_o    (pend)
  );

  logic [ID_W-1:0] src_id;
  logic            any_pend;

  irq_prio_enc #(.NUM_CH(NUM_CH)) u_prio (
    .pend_i (pend),
    .id_o   (src_id),
    .any_o  (any_pend)
  );

  // request latch: held until acknowledge, re-armed on the following cycle
  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (wr_ack)                  req_d = 1'b0;
    else if (!req_q && any_pend) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) req_q <= 1'b0;
    else            req_q <= req_d;
  end

  assign cpu_irq_o = req_q;

  always_comb begin
    unique case (sel)
      WORD_ENABLE:  bus_rdata_o = enable_q;
      WORD_PENDING: bus_rdata_o = pend;
      WORD_SOURCE:  bus_rdata_o = {{(32-ID_W){1'b0}}, src_id};
      default:      bus_rdata_o = 32'd0;
    endcase
  end

  assert_req_cause_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(cpu_irq_o) |-> $past(any_pend));
  assert_req_follows_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cpu_irq_o && any_pend && !wr_ack) |=> cpu_irq_o);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_irq_o && !wr_ack) |=> cpu_irq_o);
  assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_ack |=> !cpu_irq_o);
  assert_src_top_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    any_pend |-> (pend[src_id] && ((pend & ((32'd1 << src_id) - 32'd1)) == 32'd0)));
  assert_src_idle_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !any_pend |-> (src_id == '0));
endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  localparam int unsigned NCH   = 24;
  localparam logic [31:0] EDGE  = 32'hFF00_FF00;
  localparam logic [31:0] HIGH  = 32'h00F0_F0F0;
  localparam logic [31:0] MASK  = 32'h00FF_FFFF;
  localparam logic [31:0] IDLE  = 32'h000F_000F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = IDLE;
  logic        bus_we = 1'b0;
  logic [3:2]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;

  int n_run = 0;
  int n_fail = 0;

  logic [31:0] m_s1, m_s2, m_pv, m_pend, m_en;
  logic        m_irq;

  always #10 clk = ~clk;

  ext_irq_ctrl #(.NUM_CH(NCH), .TRIG_EDGE_MASK(EDGE), .TRIG_HIGH_MASK(HIGH)) u_ext_irq_ctrl (
    .clk (clk), .rst_n (rst_n), .irq_lines_i (irq_lines), .bus_we_i (bus_we),
    .bus_addr_i (bus_addr), .bus_wdata_i (bus_wdata), .bus_rdata_o (bus_rdata),
    .cpu_irq_o (cpu_irq)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    logic [31:0] r;
    r = 32'd0;
    case (a)
      2'd0: r = m_en;
      2'd1: r = m_pend;
      2'd2: for (int i = 31; i >= 0; i--) if (m_pend[i]) r = 32'(i);
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] fire_of(input logic [31:0] s, input logic [31:0] p);
    logic [31:0] lvl, edg;
    lvl = (s & HIGH) | (~s & ~HIGH);
    edg = (s & ~p & HIGH) | (~s & p & ~HIGH);
    return ((edg & EDGE) | (lvl & ~EDGE)) & MASK;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, step the model across the edge, return at next negedge
  task automatic cyc(input logic [31:0] in, input logic we, input logic [1:0] a, input logic [31:0] wd);
    logic [31:0] p_n, e_n;
    logic        i_n;
    irq_lines = in; bus_we = we; bus_addr = a; bus_wdata = wd;
    p_n = m_pend;
    if (we && a == 2'd1) p_n = m_pend & wd;
    p_n = (p_n | (fire_of(m_s2, m_pv) & m_en)) & MASK;
    e_n = (we && a == 2'd0) ? (wd & MASK) : m_en;
    i_n = (we && a == 2'd2) ? 1'b0 : (m_irq | (|m_pend));
    @(posedge clk);
    m_pend = p_n; m_en = e_n; m_irq = i_n;
    m_pv = m_s2; m_s2 = m_s1; m_s1 = in;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic cmp(input string tag);
    chk({31'd0, cpu_irq}, {31'd0, m_irq}, tag);
    chk(bus_rdata, exp_read(bus_addr), tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] cur;
    void'($urandom(32'd4242));
    m_s1 = '0; m_s2 = '0; m_pv = '0; m_pend = '0; m_en = '0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a);
      @(negedge clk);
      chk(bus_rdata, 32'd0, "R10 reset read");
    end
    chk({31'd0, cpu_irq}, 32'd0, "R10 reset irq");
    repeat (6) @(negedge clk);
    m_s1 = IDLE; m_s2 = IDLE; m_pv = IDLE;

    // R9 / R1: enable readback drops upper bits; unused word
    cyc(IDLE, 1'b1, 2'd0, 32'hFFFF_FFFF); chk(bus_rdata, 32'h00FF_FFFF, "R1 R9 enable readback");
    cyc(IDLE, 1'b1, 2'd3, 32'hDEAD_BEEF); chk(bus_rdata, 32'd0, "R9 unused word");
    bus_addr = 2'd0; #1 chk(bus_rdata, 32'h00FF_FFFF, "R9 unused write ignored");
    // R1: toggling upper lines never pends
    for (int k = 0; k < 6; k++) begin
      cyc(IDLE ^ (k[0] ? 32'hFF00_0000 : 32'h0), 1'b0, 2'd1, 32'd0);
      chk(bus_rdata, 32'd0, "R1 upper lines ignored");
    end
    cyc(IDLE, 1'b1, 2'd0, 32'h0000_0010);

    // R7 / R2: latency of a high-level line (channel 4)
    cyc(IDLE | 32'h10, 1'b0, 2'd1, 32'd0);
    cyc(IDLE | 32'h10, 1'b0, 2'd1, 32'd0); chk(bus_rdata, 32'd0, "R2 not yet pending after edge 2");
    cyc(IDLE | 32'h10, 1'b0, 2'd1, 32'd0); chk(bus_rdata, 32'h10, "R2 pending after edge 3");
    chk({31'd0, cpu_irq}, 32'd0, "R7 irq one cycle later");
    cyc(IDLE, 1'b0, 2'd2, 32'd0); chk({31'd0, cpu_irq}, 32'd1, "R7 irq raised");
    chk(bus_rdata, 32'd4, "R6 source index 4");
    repeat (4) begin cyc(IDLE, 1'b0, 2'd1, 32'd0); cmp("R2 level drain"); end
    // R8: clear all, irq held, then ack
    cyc(IDLE, 1'b1, 2'd1, 32'd0); chk(bus_rdata, 32'd0, "R5 clear");
    chk({31'd0, cpu_irq}, 32'd1, "R8 held without ack");
    cyc(IDLE, 1'b1, 2'd2, 32'h1234_5678); chk({31'd0, cpu_irq}, 32'd0, "R8 dropped after ack");
    chk(bus_rdata, 32'd0, "R6 idle source zero");
    cyc(IDLE, 1'b0, 2'd2, 32'd0); chk({31'd0, cpu_irq}, 32'd0, "R8 stays low");

    // R6 priority: channels 6 and 20 (high level), both enabled
    cyc(IDLE, 1'b1, 2'd0, 32'h0010_0040);
    for (int k = 0; k < 4; k++) begin cyc(IDLE | 32'h0010_0040, 1'b0, 2'd2, 32'd0); cmp("R6 priority"); end
    chk(bus_rdata, 32'd6, "R6 lowest index wins");
    // R5: trigger beats clear on same cycle; writing 1 is no-op
    cyc(IDLE | 32'h0010_0040, 1'b1, 2'd1, 32'd0); chk(bus_rdata, 32'h0010_0040, "R5 trigger wins");
    cyc(IDLE, 1'b0, 2'd1, 32'd0);
    repeat (3) cyc(IDLE, 1'b0, 2'd1, 32'd0);
    cyc(IDLE, 1'b1, 2'd1, 32'h0000_0040); chk(bus_rdata, 32'h0000_0040, "R5 ones keep, zeros clear");
    // R8: ack with pending left rearms next cycle
    cyc(IDLE, 1'b1, 2'd2, 32'd0); chk({31'd0, cpu_irq}, 32'd0, "R8 low after ack");
    cyc(IDLE, 1'b0, 2'd2, 32'd0); chk({31'd0, cpu_irq}, 32'd1, "R8 rearm with pending");
    cyc(IDLE, 1'b1, 2'd1, 32'd0); cyc(IDLE, 1'b1, 2'd2, 32'd0);

    // R4: ch21 pends, disable keeps it; ch22 triggered while disabled does not pend
    cyc(IDLE, 1'b1, 2'd0, 32'h0020_0000);
    repeat (3) cyc(IDLE | 32'h0020_0000, 1'b0, 2'd1, 32'd0);
    cyc(IDLE, 1'b1, 2'd0, 32'd0);
    repeat (5) begin cyc(IDLE | 32'h0040_0000, 1'b0, 2'd1, 32'd0); cmp("R4 gating"); end
    chk(bus_rdata & 32'h0060_0000, 32'h0020_0000, "R4 survives disable, disabled not set");
    cyc(IDLE, 1'b1, 2'd1, 32'd0); cyc(IDLE, 1'b1, 2'd2, 32'd0);

    // R3: rising ch12 and falling ch8 fire once; steady input does not refire
    cyc(IDLE | 32'h100, 1'b1, 2'd0, 32'h0000_1100);
    repeat (3) cyc(IDLE | 32'h100, 1'b0, 2'd1, 32'd0);
    cmp("R3 steady high no fire");
    cur = IDLE | 32'h1000;
    repeat (4) begin cyc(cur, 1'b0, 2'd1, 32'd0); cmp("R3 edges"); end
    chk(bus_rdata & 32'h1100, 32'h1100, "R3 rise and fall pend");
    cyc(cur, 1'b1, 2'd1, 32'd0);
    repeat (4) begin cyc(cur, 1'b0, 2'd1, 32'd0); chk(bus_rdata & 32'h1100, 32'd0, "R3 no refire"); end
    cyc(cur, 1'b1, 2'd2, 32'd0);

    // R2: low-level ch1
    cyc(cur, 1'b1, 2'd0, 32'h2);
    repeat (4) begin cyc(cur & ~32'h2, 1'b0, 2'd1, 32'd0); cmp("R2 low level"); end
    chk(bus_rdata & 32'h2, 32'h2, "R2 low level pends");

    // random phase against the model
    for (int k = 0; k < 4000; k++) begin
      logic [1:0]  a;
      logic        we;
      logic [31:0] wd;
      a  = 2'($urandom_range(0, 3));
      we = ($urandom_range(0, 3) == 0);
      wd = (a == 2'd1) ? ($urandom() | $urandom()) : $urandom();
      if ($urandom_range(0, 2) == 0) cur = cur ^ (32'd1 << $urandom_range(0, 31));
      cyc(cur, we, a, wd);
      cmp("R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule